// File: doc/BRIEF.md
# Dual Saturating Accumulator Unit

The unit holds two 40-bit signed accumulators and one shared 40-bit adder/subtracter. Each cycle the caller may name one accumulator and one operation: add the operand, subtract the operand, or load the operand. A load is the adder with its accumulator-side input forced to zero. The value that results is written back into the same accumulator one clock edge later. Subtraction inverts the operand and uses a carry-in of one, which is two's-complement subtraction through the same adder.

Each accumulator has its own saturation setting. Saturation can be off, in which case the 40-bit sum wraps. It can clamp at the signed 32-bit range, or it can clamp at the full signed 40-bit range. Each accumulator also keeps two status bits. The guard-overflow bit is rewritten on every write and shows a recoverable spill into the upper eight bits. The saturation bit is sticky and is cleared only on request. Two OR'ed summary bits and a single arithmetic trap request come from these flags and the trap enables.

Top module: `dual_acc_sat`

## Requirements
- R1: `op_code` 2'b01 adds `operand` to the accumulator chosen by `op_sel` (0 = A, 1 = B), using 40-bit two's-complement arithmetic. The result appears on that accumulator's output after the next rising clock edge.
- R2: `op_code` 2'b10 subtracts `operand` from the chosen accumulator. The result appears after the next rising clock edge.
- R3: `op_code` 2'b11 writes `operand` unchanged into the chosen accumulator. The accumulator that is not chosen keeps its value and flags. `op_code` 2'b00 changes neither accumulator nor any guard-overflow flag.
- R4: After each write, the guard-overflow flag of the written accumulator is 1 exactly when bits 39 to 32 of the new value are not all equal. Without a write, the flag holds its value.
- R5: With saturation off, the result wraps modulo 2^40. The saturation flag sets when the exact result lies outside the signed 40-bit range.
- R6: With saturation on and `sat_wide_x` = 1, an exact result above the signed 40-bit range stores 0x7FFFFFFFFF and one below it stores 0x8000000000. Either case sets the saturation flag.
- R7: With saturation on and `sat_wide_x` = 0, an exact result above 2^31-1 stores 0x007FFFFFFF and one below -2^31 stores 0xFF80000000. Either case sets the saturation flag.
- R8: A saturation flag stays set until its `sat_clr_x` is high at a clock edge. A saturation event in the same cycle as the clear leaves the flag set.
- R9: `ovf_any` is the OR of both guard-overflow flags, and `sat_any` is the OR of both saturation flags.
- R10: `trap_req` is high in either of two cases. The first is a guard-overflow flag that is set while its trap enable is high. The second is `cat_trap_en` high while a saturation flag is set whose accumulator has saturation off. `trap_req` follows these inputs and flags in the same cycle.
- R11: While `rst_n` is low, both accumulators and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 2 | 00 idle, 01 add, 10 subtract, 11 load |
| op_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| operand | input | 40 | Signed data operand |
| sat_en_a | input | 1 | Saturation on for A |
| sat_en_b | input | 1 | Saturation on for B |
| sat_wide_a | input | 1 | A clamps at 40 bits (1) or 32 bits (0) |
| sat_wide_b | input | 1 | B clamps at 40 bits (1) or 32 bits (0) |
| ovf_trap_en_a | input | 1 | Trap on A guard overflow |
| ovf_trap_en_b | input | 1 | Trap on B guard overflow |
| cat_trap_en | input | 1 | Trap on 40-bit overflow with saturation off |
| sat_clr_a | input | 1 | Clear A saturation flag |
| sat_clr_b | input | 1 | Clear B saturation flag |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A guard overflow |
| ovf_b | output | 1 | B guard overflow |
| sat_a | output | 1 | A saturation, sticky |
| sat_b | output | 1 | B saturation, sticky |
| ovf_any | output | 1 | OR of guard-overflow flags |
| sat_any | output | 1 | OR of saturation flags |
| trap_req | output | 1 | Arithmetic trap request |

## Verification
All state is architectural, so a wrong internal value shows on the ports one edge after the write that produced it.

- **Adder or source selection:** a fault corrupts the written accumulator or disturbs the other one.
- **Sign judgement in the saturation block:** a fault shows as a clamp to the wrong rail or as a missed or spurious saturation flag.
- **Flag registers:** a fault shows through `ovf_any`, `sat_any` and `trap_req` in the same cycle as the flag itself.

The sweep loads every corner value into either accumulator and applies every operand corner under each operation and saturation mode. It compares every output after each edge against an exact 64-bit model.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_LOAD = 2'b11
  } dacc_op_e;

  localparam int NUM_ACC = 2;

endpackage

// File: rtl/dacc_addsub.sv
module dacc_addsub
  import dacc_pkg::*;
#(
  parameter int W = 40
) (
  input  dacc_op_e       op,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   operand,
  output logic [W-1:0]   sum,
  output logic           msb_ovf,
  output logic           true_neg
);

  logic [W-1:0] side_acc;
  logic [W-1:0] side_opd;
  logic         cin;

  // Plain W-bit add with carry in; the carry out is not needed.
  function automatic logic [W-1:0] add_cin(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic c);
    return x + y + {{(W-1){1'b0}}, c};
  endfunction

  // Signed overflow: the inputs agree in sign and the result disagrees.
  function automatic logic sign_flip(input logic [W-1:0] x,
                                     input logic [W-1:0] y,
                                     input logic [W-1:0] s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  always_comb begin
    side_acc = (op == OP_LOAD) ? '0 : acc_in;
    side_opd = (op == OP_SUB) ? ~operand : operand;
    cin      = (op == OP_SUB);
  end

  assign sum      = add_cin(side_acc, side_opd, cin);
  assign msb_ovf  = sign_flip(side_acc, side_opd, sum);
  // When the sign is destroyed, the exact result takes the sign of the inputs.
  assign true_neg = side_acc[W-1];

endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
  parameter int W        = 40,
  parameter int NARROW_W = 32
) (
  input  logic [W-1:0] sum,
  input  logic         msb_ovf,
  input  logic         true_neg,
  input  logic         sat_en,
  input  logic         sat_wide,
  output logic [W-1:0] res,
  output logic         sat_hit
);

  localparam int NB  = NARROW_W - 1;
  localparam int EXT = W - NARROW_W + 1;

  localparam logic [W-1:0] POS_WIDE = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_WIDE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_NAR  = {{EXT{1'b0}}, {NB{1'b1}}};
  localparam logic [W-1:0] NEG_NAR  = {{EXT{1'b1}}, {NB{1'b0}}};

  logic narrow_oor;
  logic neg_dir;

  // True when the top bits down to the narrow sign bit are not one sign extension.
  function automatic logic outside_narrow(input logic [W-1:0] v);
    return !((&v[W-1:NB]) || !(|v[W-1:NB]));
  endfunction

  function automatic logic [W-1:0] clamp(input logic neg, input logic wide);
    if (wide) return neg ? NEG_WIDE : POS_WIDE;
    else      return neg ? NEG_NAR : POS_NAR;
  endfunction

  assign narrow_oor = msb_ovf | outside_narrow(sum);
  assign neg_dir    = msb_ovf ? true_neg : sum[W-1];

  always_comb begin
    res     = sum;
    sat_hit = msb_ovf;
    if (sat_en) begin
      if (sat_wide) begin
        if (msb_ovf) res = clamp(true_neg, 1'b1);
      end else begin
        sat_hit = narrow_oor;
        if (narrow_oor) res = clamp(neg_dir, 1'b0);
      end
    end
  end

endmodule

// File: rtl/dacc_bank.sv
module dacc_bank #(
  parameter int W        = 40,
  parameter int GUARD_LO = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         sat_set,
  input  logic         sat_clr,
  output logic [W-1:0] acc_q,
  output logic         ovf_q,
  output logic         sat_q
);

  function automatic logic guard_mixed(input logic [W-1:0] v);
    return !((&v[W-1:GUARD_LO]) || !(|v[W-1:GUARD_LO]));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (wr_en) begin
        acc_q <= wr_val;
        ovf_q <= guard_mixed(wr_val);
      end
      sat_q <= (sat_q & ~sat_clr) | sat_set;
    end
  end

endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat
  import dacc_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32,
  parameter int GUARD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_code,
  input  logic             op_sel,
  input  logic [ACC_W-1:0] operand,
  input  logic             sat_en_a,
  input  logic             sat_en_b,
  input  logic             sat_wide_a,
  input  logic             sat_wide_b,
  input  logic             ovf_trap_en_a,
  input  logic             ovf_trap_en_b,
  input  logic             cat_trap_en,
  input  logic             sat_clr_a,
  input  logic             sat_clr_b,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             sat_a,
  output logic             sat_b,
  output logic             ovf_any,
  output logic             sat_any,
  output logic             trap_req
);

  localparam int GUARD_LO = ACC_W - GUARD_W;

  dacc_op_e                        op;
  logic [NUM_ACC-1:0][ACC_W-1:0]   acc_q;
  logic [NUM_ACC-1:0]              ovf_q;
  logic [NUM_ACC-1:0]              sat_q;
  logic [NUM_ACC-1:0]              sat_en_v;
  logic [NUM_ACC-1:0]              sat_wide_v;
  logic [NUM_ACC-1:0]              sat_clr_v;
  logic [NUM_ACC-1:0]              ovf_trap_v;
  logic [NUM_ACC-1:0]              wr_en;
  logic [NUM_ACC-1:0]              sat_set;

  logic [ACC_W-1:0] src_acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] res;
  logic             msb_ovf;
  logic             true_neg;
  logic             sat_hit;

  assign op         = dacc_op_e'(op_code);
  assign sat_en_v   = {sat_en_b, sat_en_a};
  assign sat_wide_v = {sat_wide_b, sat_wide_a};
  assign sat_clr_v  = {sat_clr_b, sat_clr_a};
  assign ovf_trap_v = {ovf_trap_en_b, ovf_trap_en_a};
  assign src_acc    = acc_q[op_sel];

  dacc_addsub #(.W(ACC_W)) u_addsub (
    .op       (op),
    .acc_in   (src_acc),
    .operand  (operand),
    .sum      (sum),
    .msb_ovf  (msb_ovf),
    .true_neg (true_neg)
  );

  dacc_sat #(.W(ACC_W), .NARROW_W(NARROW_W)) u_sat (
    .sum      (sum),
    .msb_ovf  (msb_ovf),
    .true_neg (true_neg),
    .sat_en   (sat_en_v[op_sel]),
    .sat_wide (sat_wide_v[op_sel]),
    .res      (res),
    .sat_hit  (sat_hit)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_bank
    assign wr_en[i]   = (op != OP_IDLE) && (op_sel == 1'(i));
    assign sat_set[i] = wr_en[i] & sat_hit;

    dacc_bank #(.W(ACC_W), .GUARD_LO(GUARD_LO)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[i]),
      .wr_val  (res),
      .sat_set (sat_set[i]),
      .sat_clr (sat_clr_v[i]),
      .acc_q   (acc_q[i]),
      .ovf_q   (ovf_q[i]),
      .sat_q   (sat_q[i])
    );
  end

  assign acc_a    = acc_q[0];
  assign acc_b    = acc_q[1];
  assign ovf_a    = ovf_q[0];
  assign ovf_b    = ovf_q[1];
  assign sat_a    = sat_q[0];
  assign sat_b    = sat_q[1];
  assign ovf_any  = |ovf_q;
  assign sat_any  = |sat_q;
  assign trap_req = (|(ovf_q & ovf_trap_v)) | (cat_trap_en & (|(sat_q & ~sat_en_v)));

endmodule

// File: rtl/dacc_chk.sv
module dacc_chk #(
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32,
  parameter int GUARD_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       op_code,
  input logic             op_sel,
  input logic             sat_en_a,
  input logic             sat_wide_a,
  input logic             sat_clr_a,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             sat_a,
  input logic             wr_en_a,
  input logic             sat_hit
);

  localparam int GLO = ACC_W - GUARD_W;
  localparam int NB  = NARROW_W - 1;

  // R3: A untouched unless an operation targets it
  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !((op_code != 2'b00) && !op_sel) |=> ($stable(acc_a) && $stable(ovf_a)));

  // R3: B untouched unless an operation targets it
  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !((op_code != 2'b00) && op_sel) |=> ($stable(acc_b) && $stable(ovf_b)));

  // R4: guard flag agrees with the stored guard bits
  a_r4_ovf_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a == !((&acc_a[ACC_W-1:GLO]) || !(|acc_a[ACC_W-1:GLO])));

  // R7: a narrow-mode write always lands inside the 32-bit range
  a_r7_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_a && sat_en_a && !sat_wide_a) |=>
      ((&acc_a[ACC_W-1:NB]) || !(|acc_a[ACC_W-1:NB])));

  // R8: sticky flag survives until cleared
  a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_a && !sat_clr_a) |=> sat_a);

  // R8: a saturation event on A sets the flag even against a clear
  a_r8_sat_event: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_a && sat_hit) |=> sat_a);

endmodule

bind dual_acc_sat dacc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_code    (op_code),
  .op_sel     (op_sel),
  .sat_en_a   (sat_en_a),
  .sat_wide_a (sat_wide_a),
  .sat_clr_a  (sat_clr_a),
  .acc_a      (acc_a),
  .acc_b      (acc_b),
  .ovf_a      (ovf_a),
  .ovf_b      (ovf_b),
  .sat_a      (sat_a),
  .wr_en_a    (wr_en[0]),
  .sat_hit    (sat_hit)
);

// File: tb/dual_acc_sat_tb.sv
module dual_acc_sat_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_code;
  logic        op_sel;
  logic [39:0] operand;
  logic        sat_en_a, sat_en_b, sat_wide_a, sat_wide_b;
  logic        ovf_trap_en_a, ovf_trap_en_b, cat_trap_en;
  logic        sat_clr_a, sat_clr_b;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any, trap_req;

  int checks = 0;
  int errors = 0;

  logic [39:0] m_acc [2];
  logic        m_ovf [2];
  logic        m_sat [2];

  localparam logic [39:0] VALS [9] = '{
    40'h00_0000_0000, 40'h00_0000_0001, 40'hFF_FFFF_FFFF,
    40'h00_7FFF_FFFF, 40'hFF_8000_0000, 40'h7F_FFFF_FFFF,
    40'h80_0000_0000, 40'h01_2345_6789, 40'h00_8000_0000
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_acc_sat u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_sel(op_sel), .operand(operand),
    .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_wide_a(sat_wide_a), .sat_wide_b(sat_wide_b),
    .ovf_trap_en_a(ovf_trap_en_a), .ovf_trap_en_b(ovf_trap_en_b), .cat_trap_en(cat_trap_en),
    .sat_clr_a(sat_clr_a), .sat_clr_b(sat_clr_b), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b),
    .ovf_any(ovf_any), .sat_any(sat_any), .trap_req(trap_req)
  );

  function automatic longint sx(input logic [39:0] v);
    return longint'($signed({{24{v[39]}}, v}));
  endfunction

  function automatic logic mixed_guard(input logic [39:0] v);
    return !(v[39:32] == 8'h00 || v[39:32] == 8'hFF);
  endfunction

  task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic exp_trap;
    exp_trap = (m_ovf[0] & ovf_trap_en_a) | (m_ovf[1] & ovf_trap_en_b) |
               (cat_trap_en & ((m_sat[0] & ~sat_en_a) | (m_sat[1] & ~sat_en_b)));
    chk(req, "acc_a", acc_a, m_acc[0]);
    chk(req, "acc_b", acc_b, m_acc[1]);
    chk(req, "ovf_a", {39'd0, ovf_a}, {39'd0, m_ovf[0]});
    chk(req, "ovf_b", {39'd0, ovf_b}, {39'd0, m_ovf[1]});
    chk(req, "sat_a", {39'd0, sat_a}, {39'd0, m_sat[0]});
    chk(req, "sat_b", {39'd0, sat_b}, {39'd0, m_sat[1]});
    chk("R9", "ovf_any", {39'd0, ovf_any}, {39'd0, m_ovf[0] | m_ovf[1]});
    chk("R9", "sat_any", {39'd0, sat_any}, {39'd0, m_sat[0] | m_sat[1]});
    chk("R10", "trap_req", {39'd0, trap_req}, {39'd0, exp_trap});
  endtask

  // mode: 0 = saturation off, 1 = 32-bit clamp, 2 = 40-bit clamp
  task automatic do_op(input int sel, input logic [1:0] opc, input logic [39:0] val,
                       input int mode, input logic clr_a, input logic clr_b, input string req);
    longint exact, hi40, lo40, hi32, lo32;
    logic [39:0] r;
    logic evt;
    hi40 = (64'sd1 <<< 39) - 1; lo40 = -(64'sd1 <<< 39);
    hi32 = (64'sd1 <<< 31) - 1; lo32 = -(64'sd1 <<< 31);
    op_code = opc; op_sel = sel[0]; operand = val;
    sat_clr_a = clr_a; sat_clr_b = clr_b;
    if (sel == 0) begin sat_en_a = (mode != 0); sat_wide_a = (mode == 2); end
    else          begin sat_en_b = (mode != 0); sat_wide_b = (mode == 2); end
    evt = 1'b0;
    if (opc != 2'b00) begin
      case (opc)
        2'b01:   exact = sx(m_acc[sel]) + sx(val);
        2'b10:   exact = sx(m_acc[sel]) - sx(val);
        default: exact = sx(val);
      endcase
      r = exact[39:0];
      if (mode == 0) begin
        evt = (exact > hi40) || (exact < lo40);
      end else if (mode == 2) begin
        evt = (exact > hi40) || (exact < lo40);
        if (exact > hi40) r = 40'h7F_FFFF_FFFF;
        if (exact < lo40) r = 40'h80_0000_0000;
      end else begin
        evt = (exact > hi32) || (exact < lo32);
        if (exact > hi32) r = 40'h00_7FFF_FFFF;
        if (exact < lo32) r = 40'hFF_8000_0000;
      end
      m_acc[sel] = r;
      m_ovf[sel] = mixed_guard(r);
    end
    m_sat[0] = (m_sat[0] & ~clr_a) | (sel == 0 && evt);
    m_sat[1] = (m_sat[1] & ~clr_b) | (sel == 1 && evt);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic string req_of(input logic [1:0] opc, input int mode);
    if (mode == 1) return "R7";
    if (mode == 2) return "R6";
    if (opc == 2'b01) return "R1";
    if (opc == 2'b10) return "R2";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_code = 2'b00; op_sel = 1'b0; operand = '0;
    sat_en_a = 0; sat_en_b = 0; sat_wide_a = 0; sat_wide_b = 0;
    ovf_trap_en_a = 0; ovf_trap_en_b = 0; cat_trap_en = 0;
    sat_clr_a = 0; sat_clr_b = 0;
    for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11");

    // Main sweep over target, mode, operation and operand corners (R1, R2, R5, R6, R7)
    for (int sel = 0; sel < 2; sel++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int opi = 1; opi < 4; opi++) begin
          for (int ai = 0; ai < 9; ai++) begin
            for (int bi = 0; bi < 9; bi++) begin
              ovf_trap_en_a = ai[0]; ovf_trap_en_b = bi[0]; cat_trap_en = ai[1] ^ bi[1];
              // R3: load the starting value, clearing both sticky flags
              do_op(sel, 2'b11, VALS[ai], 0, 1'b1, 1'b1, "R3");
              do_op(sel, 2'(opi), VALS[bi], mode, 1'b0, 1'b0, req_of(2'(opi), mode));
            end
          end
        end
      end
    end

    // R3: idle leaves everything as is
    do_op(0, 2'b00, 40'h12_3456_789A, 0, 1'b0, 1'b0, "R3");
    do_op(1, 2'b00, 40'h00_0000_0001, 2, 1'b0, 1'b0, "R3");

    // R8: sticky flag and clear collision on A
    ovf_trap_en_a = 1; ovf_trap_en_b = 0; cat_trap_en = 1;
    do_op(0, 2'b11, 40'h7F_FFFF_FFFF, 0, 1'b1, 1'b1, "R4");
    do_op(0, 2'b01, 40'h00_0000_0001, 0, 1'b0, 1'b0, "R5");
    do_op(0, 2'b00, 40'h0, 0, 1'b0, 1'b0, "R8");
    do_op(0, 2'b11, 40'h7F_FFFF_FFFF, 0, 1'b0, 1'b0, "R8");
    do_op(0, 2'b01, 40'h00_0000_0001, 0, 1'b1, 1'b0, "R8");
    do_op(0, 2'b00, 40'h0, 0, 1'b1, 1'b0, "R8");
    do_op(0, 2'b00, 40'h0, 0, 1'b0, 1'b0, "R8");

    // R8 and R10: B saturates at 32 bits with saturation on; the catastrophic trap stays quiet
    do_op(1, 2'b11, 40'h00_7FFF_FFFF, 1, 1'b0, 1'b0, "R3");
    do_op(1, 2'b01, 40'h00_0000_0005, 1, 1'b0, 1'b0, "R7");
    do_op(1, 2'b00, 40'h0, 1, 1'b0, 1'b0, "R10");
    sat_en_b = 1'b0;
    @(negedge clk);
    check_all("R10");
    do_op(1, 2'b00, 40'h0, 0, 1'b0, 1'b1, "R8");

    op_code = 2'b00; sat_clr_a = 0; sat_clr_b = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule